// File: doc/BRIEF.md
# Write-Enable Sequencing and Write-Protection Controller

This block sits between the serial bus bit engine and the storage of a combined memory and clock device. It holds the two volatile write-enable latches, the clock-fail flag and the three-bit block-protect code. For each decoded bus event (start, stop, slave byte, address, data byte, read), it decides whether the device acknowledges. It also raises a one-cycle strobe that starts a nonvolatile write cycle, and it reports busy for as long as that cycle lasts.

Control-register writes are allowed only after a two-step unlock. A status write of 02h sets the write-enable latch. A status write of 06h then sets the register-write-enable latch as well. When a nonvolatile cycle finishes, the register-write-enable latch drops again, so the unlock has to be repeated before the next control-register write. Array writes need only the write-enable latch, and they are refused inside the segment that the protect code selects.

Top module: `wr_enable_guard`

## Requirements
- R1: After a synchronous reset, both latches are clear and busy is low. The protect code equals parameter BP_INIT. The clock-fail flag equals the `lostAllPower` input sampled during reset. The status byte is {bit7 busy, bits 6..3 zero, bit2 register-write-enable, bit1 write-enable, bit0 clock-fail}.
- R2: Status writes go through slave byte DEh at control address 3Fh and are always acknowledged. A value of 02h sets write-enable and clears register-write-enable. A value of 06h, written while write-enable is set, sets both latches. A value of 00h clears both. None of these writes causes an nvStart or a busy period.
- R3: Any other status value leaves both latches unchanged. This includes a value with a nonzero bit among bits 3..6, and 06h written while write-enable is clear.
- R4: While write-enable is clear, a data byte to the array is not acknowledged. A data byte to a control address other than 3Fh is not acknowledged unless both latches are set. A refused byte has no effect.
- R5: Slave byte DEh selects the control space and AEh selects the array; any other slave byte is not acknowledged. A control address is acknowledged only if it is below 40h. Every array address is acknowledged.
- R6: One control-register transaction acknowledges at most 8 data bytes; later bytes are refused. Bytes to undefined control addresses are acknowledged but change nothing.
- R7: A stop that ends a transaction with at least one accepted array or non-status control byte gives nvStart high for one cycle, in the cycle after the stop. Busy is then high for exactly NV_TICKS cycles. A stop with no such byte gives no nvStart.
- R8: While busy is high, a slave byte is not acknowledged.
- R9: When the nonvolatile cycle ends, register-write-enable clears and write-enable keeps its value.
- R10: An accepted byte to a clock register (control addresses 30h..37h) clears the clock-fail flag. Array writes and writes to other control addresses leave it unchanged.
- R11: An array data byte is refused when its address lies in the range selected by the protect code: 0 none, 1 600h-7FFh, 2 400h-7FFh, 3 000h-7FFh, 4 000h-03Fh, 5 000h-07Fh, 6 000h-0FFh, 7 000h-1FFh. Outside that range, it is acknowledged while write-enable is set. The address advances by one after each array byte.
- R12: The protect code changes only through an accepted data byte to control address 10h, which loads data bits 2..0. The new value appears on bpOut in the cycle after that byte.
- R13: A read event during a control transaction returns rdData in the next cycle, with rdValid high. Address 3Fh returns the status byte, 10h returns {5'b0, protect code}, and any other address returns 00h. The address advances by one after each read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| lostAllPower | input | 1 | High during reset when every supply had been lost |
| startEv | input | 1 | Start condition seen |
| stopEv | input | 1 | Stop condition seen |
| slaveEv | input | 1 | Slave byte on busByte |
| addrEv | input | 1 | Word address on busAddr |
| dataEv | input | 1 | Write data byte on busByte |
| readEv | input | 1 | Read byte requested |
| busByte | input | 8 | Slave or data byte |
| busAddr | input | AW | Word address |
| ackValid | output | 1 | An acknowledge decision is present |
| ackOut | output | 1 | 1 acknowledge, 0 refuse |
| nvStart | output | 1 | Start a nonvolatile write cycle |
| busy | output | 1 | Nonvolatile cycle in progress |
| statusOut | output | 8 | Status byte |
| bpOut | output | 3 | Block-protect code |
| rdValid | output | 1 | rdData is valid |
| rdData | output | 8 | Read-back byte |

## Verification
If a latch holds the wrong value, it shows on statusOut in the cycle after the status write that set it. It also shows as a wrong ackOut on the next data byte to the array or to the control space. If the protect decode or the address pointer is wrong, ackOut is wrong on the first byte that touches a segment boundary. The sweep therefore writes both sides of every boundary under all eight protect codes. A wrong nonvolatile timer shows as an nvStart in the wrong cycle, a busy period of the wrong length, or register-write-enable still set after busy falls.

// File: rtl/weg_pkg.sv
package weg_pkg;
  localparam logic [7:0] SLAVE_CTRL = 8'hDE;
  localparam logic [7:0] SLAVE_ARRAY = 8'hAE;

  typedef enum logic [1:0] {PH_IDLE, PH_SLAVE, PH_ADDR, PH_DATA} phase_t;
  typedef enum logic [1:0] {TG_NONE, TG_CTRL, TG_ARRAY} target_t;

  typedef struct packed {
    logic statWr;
    logic bpWr;
    logic rtcWr;
    logic nvKick;
    logic rdReq;
  } strobe_t;
endpackage

// File: rtl/weg_sequencer.sv
module weg_sequencer
  import weg_pkg::*;
#(
  parameter int AW = 11,
  parameter int CAW = 6,
  parameter int MAX_BURST = 8,
  parameter int STAT_ADDR = 'h3F,
  parameter int BP_ADDR = 'h10,
  parameter int RTC_BASE = 'h30,
  parameter int RTC_NUM = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          startEv,
  input  logic          stopEv,
  input  logic          slaveEv,
  input  logic          addrEv,
  input  logic          dataEv,
  input  logic          readEv,
  input  logic [7:0]    busByte,
  input  logic [AW-1:0] busAddr,
  input  logic          wel,
  input  logic          rwel,
  input  logic          busy,
  input  logic          protHit,
  output strobe_t       stb,
  output logic [AW-1:0] ptr,
  output logic          ackValid,
  output logic          ackOut,
  output logic          nvStart
);
  localparam int CW = $clog2(MAX_BURST + 1);

  phase_t phase, phaseN;
  target_t tgt, tgtN;
  logic [AW-1:0] ptrN;
  logic [CW-1:0] cnt, cntN;
  logic dirty, dirtyN;
  logic ackV, ackN;
  logic [CAW-1:0] ctrlIdx, ctrlInc;
  logic isStat, isRtc, ctrlOk;

  assign ctrlIdx = ptr[CAW-1:0];
  assign ctrlInc = ctrlIdx + 1'b1;
  assign isStat = (ctrlIdx == CAW'(STAT_ADDR));
  assign isRtc = (int'(ctrlIdx) >= RTC_BASE) && (int'(ctrlIdx) < RTC_BASE + RTC_NUM);
  assign ctrlOk = wel && rwel && (cnt < CW'(MAX_BURST));

  always_comb begin
    phaseN = phase;
    tgtN = tgt;
    ptrN = ptr;
    cntN = cnt;
    dirtyN = dirty;
    ackV = 1'b0;
    ackN = 1'b0;
    stb = '0;
    if (startEv) begin
      phaseN = PH_SLAVE;
      tgtN = TG_NONE;
      cntN = '0;
    end else if (stopEv) begin
      stb.nvKick = dirty;
      dirtyN = 1'b0;
      phaseN = PH_IDLE;
      tgtN = TG_NONE;
    end else if (slaveEv) begin
      ackV = 1'b1;
      phaseN = PH_IDLE;
      if (phase == PH_SLAVE && !busy) begin
        if (busByte == SLAVE_CTRL) begin
          ackN = 1'b1;
          tgtN = TG_CTRL;
          phaseN = PH_ADDR;
        end else if (busByte == SLAVE_ARRAY) begin
          ackN = 1'b1;
          tgtN = TG_ARRAY;
          phaseN = PH_ADDR;
        end
      end
    end else if (addrEv) begin
      ackV = 1'b1;
      phaseN = PH_IDLE;
      if (phase == PH_ADDR) begin
        if (tgt == TG_ARRAY || busAddr[AW-1:CAW] == '0) begin
          ackN = 1'b1;
          ptrN = busAddr;
          phaseN = PH_DATA;
        end
      end
    end else if (dataEv) begin
      ackV = 1'b1;
      if (phase == PH_DATA) begin
        if (tgt == TG_ARRAY) begin
          ackN = wel && !protHit;
          dirtyN = dirty || ackN;
          ptrN = ptr + 1'b1;
        end else if (isStat) begin
          ackN = 1'b1;
          stb.statWr = 1'b1;
          ptrN = AW'(ctrlInc);
        end else begin
          ackN = ctrlOk;
          if (ctrlOk) begin
            dirtyN = 1'b1;
            cntN = cnt + 1'b1;
            stb.bpWr = (ctrlIdx == CAW'(BP_ADDR));
            stb.rtcWr = isRtc;
          end
          ptrN = AW'(ctrlInc);
        end
      end
    end else if (readEv && phase == PH_DATA && tgt == TG_CTRL) begin
      stb.rdReq = 1'b1;
      ptrN = AW'(ctrlInc);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      tgt <= TG_NONE;
      ptr <= '0;
      cnt <= '0;
      dirty <= 1'b0;
      ackValid <= 1'b0;
      ackOut <= 1'b0;
      nvStart <= 1'b0;
    end else begin
      phase <= phaseN;
      tgt <= tgtN;
      ptr <= ptrN;
      cnt <= cntN;
      dirty <= dirtyN;
      ackValid <= ackV;
      ackOut <= ackN;
      nvStart <= stb.nvKick;
    end
  end
endmodule

// File: rtl/weg_state.sv
module weg_state
  import weg_pkg::*;
#(
  parameter int AW = 11,
  parameter int CAW = 6,
  parameter int PAGE_BITS = 6,
  parameter int NV_TICKS = 2500000,
  parameter logic [2:0] BP_INIT = 3'd0,
  parameter int STAT_ADDR = 'h3F,
  parameter int BP_ADDR = 'h10
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          lostAllPower,
  input  strobe_t       stb,
  input  logic [7:0]    busByte,
  input  logic [AW-1:0] ptr,
  output logic          wel,
  output logic          rwel,
  output logic          busy,
  output logic          protHit,
  output logic [7:0]    statusOut,
  output logic [2:0]    bpOut,
  output logic          rdValid,
  output logic [7:0]    rdData
);
  localparam int TW = $clog2(NV_TICKS + 1);

  logic rtcFail;
  logic [TW-1:0] timer;

  assign busy = (timer != '0);
  assign statusOut = {busy, 4'b0000, rwel, wel, rtcFail};

  always_comb begin
    case (bpOut)
      3'd0: protHit = 1'b0;
      3'd1: protHit = (ptr[AW-1:AW-2] == 2'b11);
      3'd2: protHit = ptr[AW-1];
      3'd3: protHit = 1'b1;
      default: protHit = ((ptr >> (PAGE_BITS + int'(bpOut[1:0]))) == '0);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wel <= 1'b0;
      rwel <= 1'b0;
      rtcFail <= lostAllPower;
      bpOut <= BP_INIT;
      timer <= '0;
      rdValid <= 1'b0;
      rdData <= '0;
    end else begin
      if (stb.statWr) begin
        case (busByte)
          8'h00: begin wel <= 1'b0; rwel <= 1'b0; end
          8'h02: begin wel <= 1'b1; rwel <= 1'b0; end
          8'h06: if (wel) rwel <= 1'b1;
          default: ;
        endcase
      end
      if (timer == TW'(1)) rwel <= 1'b0;
      if (stb.bpWr) bpOut <= busByte[2:0];
      if (stb.rtcWr) rtcFail <= 1'b0;
      if (stb.nvKick) timer <= TW'(NV_TICKS);
      else if (busy) timer <= timer - 1'b1;
      rdValid <= stb.rdReq;
      if (stb.rdReq) begin
        if (ptr[CAW-1:0] == CAW'(STAT_ADDR)) rdData <= statusOut;
        else if (ptr[CAW-1:0] == CAW'(BP_ADDR)) rdData <= {5'b00000, bpOut};
        else rdData <= 8'h00;
      end
    end
  end
endmodule

// File: rtl/wr_enable_guard.sv
module wr_enable_guard
  import weg_pkg::*;
#(
  parameter int AW = 11,
  parameter int PAGE_BITS = 6,
  parameter int NV_TICKS = 2500000,
  parameter logic [2:0] BP_INIT = 3'd0
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          lostAllPower,
  input  logic          startEv,
  input  logic          stopEv,
  input  logic          slaveEv,
  input  logic          addrEv,
  input  logic          dataEv,
  input  logic          readEv,
  input  logic [7:0]    busByte,
  input  logic [AW-1:0] busAddr,
  output logic          ackValid,
  output logic          ackOut,
  output logic          nvStart,
  output logic          busy,
  output logic [7:0]    statusOut,
  output logic [2:0]    bpOut,
  output logic          rdValid,
  output logic [7:0]    rdData
);
  localparam int CAW = 6;

  strobe_t stb;
  logic [AW-1:0] ptr;
  logic wel, rwel, protHit;

  weg_sequencer #(.AW(AW), .CAW(CAW)) u_seq (
    .clk(clk), .rstN(rstN), .startEv(startEv), .stopEv(stopEv),
    .slaveEv(slaveEv), .addrEv(addrEv), .dataEv(dataEv), .readEv(readEv),
    .busByte(busByte), .busAddr(busAddr), .wel(wel), .rwel(rwel),
    .busy(busy), .protHit(protHit), .stb(stb), .ptr(ptr),
    .ackValid(ackValid), .ackOut(ackOut), .nvStart(nvStart)
  );

  weg_state #(.AW(AW), .CAW(CAW), .PAGE_BITS(PAGE_BITS), .NV_TICKS(NV_TICKS),
              .BP_INIT(BP_INIT)) u_state (
    .clk(clk), .rstN(rstN), .lostAllPower(lostAllPower), .stb(stb),
    .busByte(busByte), .ptr(ptr), .wel(wel), .rwel(rwel), .busy(busy),
    .protHit(protHit), .statusOut(statusOut), .bpOut(bpOut),
    .rdValid(rdValid), .rdData(rdData)
  );
endmodule

// File: rtl/weg_checker.sv
module weg_checker (
  input logic       clk,
  input logic       rstN,
  input logic       slaveEv,
  input logic       ackValid,
  input logic       ackOut,
  input logic       nvStart,
  input logic       busy,
  input logic [7:0] statusOut,
  input logic [2:0] bpOut
);
  p_busy_nack_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && slaveEv) |=> (ackValid && !ackOut));

  p_rwel_drop_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> !statusOut[2]);

  p_kick_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    nvStart |-> busy);

  p_rwel_wel_r2: assert property (@(posedge clk) disable iff (!rstN)
    statusOut[2] |-> statusOut[1]);

  p_bp_needs_ack_r12: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(bpOut) |-> (ackValid && ackOut));
endmodule

bind wr_enable_guard weg_checker u_chk (
  .clk(clk), .rstN(rstN), .slaveEv(slaveEv), .ackValid(ackValid),
  .ackOut(ackOut), .nvStart(nvStart), .busy(busy), .statusOut(statusOut),
  .bpOut(bpOut)
);

// File: tb/sim_wr_enable_guard.sv
`timescale 1ns/1ps
module sim_wr_enable_guard;
  localparam int AW = 11;
  localparam int NVT = 20;

  logic clk = 0, rstN = 0, lostAllPower = 1;
  logic startEv = 0, stopEv = 0, slaveEv = 0, addrEv = 0, dataEv = 0, readEv = 0;
  logic [7:0] busByte = 0;
  logic [AW-1:0] busAddr = 0;
  logic ackValid, ackOut, nvStart, busy, rdValid;
  logic [7:0] statusOut, rdData;
  logic [2:0] bpOut;

  int checks = 0, errors = 0;
  bit done = 0;
  int expQ[$];
  string tagQ[$];

  wr_enable_guard #(.AW(AW), .NV_TICKS(NVT), .BP_INIT(3'd0)) u0 (
    .clk(clk), .rstN(rstN), .lostAllPower(lostAllPower), .startEv(startEv),
    .stopEv(stopEv), .slaveEv(slaveEv), .addrEv(addrEv), .dataEv(dataEv),
    .readEv(readEv), .busByte(busByte), .busAddr(busAddr), .ackValid(ackValid),
    .ackOut(ackOut), .nvStart(nvStart), .busy(busy), .statusOut(statusOut),
    .bpOut(bpOut), .rdValid(rdValid), .rdData(rdData)
  );

  always #2 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && ackValid) begin
      if (expQ.size() == 0) chk("unexpected ack", 1, 0);
      else chk(tagQ.pop_front(), int'(ackOut), expQ.pop_front());
    end
  end

  task automatic doStart();
    @(negedge clk); startEv = 1; @(negedge clk); startEv = 0;
  endtask
  task automatic doStop(input int expNv, input string tag);
    @(negedge clk); stopEv = 1; @(negedge clk); stopEv = 0;
    chk(tag, int'(nvStart), expNv);
  endtask
  task automatic doSlave(input logic [7:0] b, input int exp, input string tag);
    @(negedge clk); slaveEv = 1; busByte = b; expQ.push_back(exp); tagQ.push_back(tag);
    @(negedge clk); slaveEv = 0;
  endtask
  task automatic doAddr(input int a, input int exp, input string tag);
    @(negedge clk); addrEv = 1; busAddr = AW'(a); expQ.push_back(exp); tagQ.push_back(tag);
    @(negedge clk); addrEv = 0;
  endtask
  task automatic doData(input logic [7:0] b, input int exp, input string tag);
    @(negedge clk); dataEv = 1; busByte = b; expQ.push_back(exp); tagQ.push_back(tag);
    @(negedge clk); dataEv = 0;
  endtask
  task automatic doRead(input int exp, input string tag);
    @(negedge clk); readEv = 1; @(negedge clk); readEv = 0;
    chk({tag, " valid"}, int'(rdValid), 1);
    chk(tag, int'(rdData), exp);
  endtask
  task automatic waitIdle();
    for (int i = 0; i < 1000 && busy; i++) @(negedge clk);
  endtask
  task automatic statusWrite(input logic [7:0] v, input string tag);
    doStart(); doSlave(8'hDE, 1, tag); doAddr('h3F, 1, tag); doData(v, 1, tag);
    doStop(0, {tag, " no nv"});
  endtask
  task automatic arrWrite(input int a, input int exp, input string tag);
    doStart(); doSlave(8'hAE, 1, tag); doAddr(a, 1, tag); doData(8'h5A, exp, tag);
    doStop(exp, {tag, " nv"}); waitIdle();
  endtask
  task automatic setBp(input int code);
    statusWrite(8'h06, "R2 unlock");
    doStart(); doSlave(8'hDE, 1, "R12 bp"); doAddr('h10, 1, "R12 bp");
    doData(8'(code), 1, "R12 bp"); doStop(1, "R7 bp nv"); waitIdle();
    chk("R12 bp value", int'(bpOut), code);
  endtask

  function automatic int protExp(input int bp, input int a);
    case (bp)
      0: return 0;
      1: return int'(a >= 'h600);
      2: return int'(a >= 'h400);
      3: return 1;
      4: return int'(a <= 'h3F);
      5: return int'(a <= 'h7F);
      6: return int'(a <= 'hFF);
      default: return int'(a <= 'h1FF);
    endcase
  endfunction

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int cnt;
    int addrs[14] = '{'h000, 'h03F, 'h040, 'h07F, 'h080, 'h0FF, 'h100,
                      'h1FF, 'h200, 'h3FF, 'h400, 'h5FF, 'h600, 'h7FF};
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1 status after reset", int'(statusOut), 'h01);
    chk("R1 bp after reset", int'(bpOut), 0);
    chk("R1 busy after reset", int'(busy), 0);

    arrWrite('h100, 0, "R4 array without WEL");
    doStart(); doSlave(8'hDE, 1, "R5 ctrl slave"); doAddr('h10, 1, "R5 ctrl addr");
    doData(8'h03, 0, "R4 ctrl without latches"); doStop(0, "R7 no nv");
    chk("R12 bp unchanged", int'(bpOut), 0);

    statusWrite(8'h06, "R3 06 without WEL");
    chk("R3 latches after 06", int'(statusOut), 'h01);
    statusWrite(8'h02, "R2 set WEL");
    chk("R2 WEL set", int'(statusOut), 'h03);
    chk("R2 no busy", int'(busy), 0);
    arrWrite('h000, 1, "R11 array bp0");
    chk("R10 flag kept after array", int'(statusOut), 'h03);
    statusWrite(8'h12, "R3 reserved bits");
    chk("R3 latches after 12h", int'(statusOut), 'h03);
    statusWrite(8'h06, "R2 set both");
    chk("R2 both set", int'(statusOut), 'h07);

    doStart(); doSlave(8'hDE, 1, "R6 burst"); doAddr('h2E, 1, "R6 burst");
    for (int i = 0; i < 8; i++) doData(8'h11, 1, "R6 burst byte");
    doData(8'h11, 0, "R6 ninth byte");
    doStop(1, "R7 nvStart after burst");
    cnt = 0;
    while (busy && cnt < 1000) begin cnt++; @(negedge clk); end
    chk("R7 busy length", cnt, NVT);
    chk("R9 RWEL cleared, WEL kept, R10 flag cleared", int'(statusOut), 'h02);
    chk("R6 undefined no effect", int'(bpOut), 0);

    statusWrite(8'h06, "R2 unlock again");
    doStart(); doSlave(8'hDE, 1, "R12 bp write"); doAddr('h10, 1, "R12 bp write");
    doData(8'h05, 1, "R12 bp write");
    chk("R12 bp loaded", int'(bpOut), 5);
    doData(8'hFF, 1, "R6 undefined byte");
    doStop(1, "R7 nv after bp");
    doStart(); doSlave(8'hDE, 0, "R8 slave while busy"); doStop(0, "R8 no nv");
    waitIdle();
    chk("R9 status after cycle", int'(statusOut), 'h02);
    chk("R6 bp after undefined", int'(bpOut), 5);

    doStart(); doSlave(8'hDE, 1, "R13 read"); doAddr('h10, 1, "R13 read");
    doRead(5, "R13 read bp"); doRead(0, "R13 read undefined"); doStop(0, "R13 no nv");
    doStart(); doSlave(8'hDE, 1, "R13 read"); doAddr('h3F, 1, "R13 read");
    doRead('h02, "R13 read status"); doStop(0, "R13 no nv");

    doStart(); doSlave(8'hA0, 0, "R5 bad slave"); doStop(0, "R5 no nv");
    doStart(); doSlave(8'hDE, 1, "R5 ctrl slave"); doAddr('h40, 0, "R5 ctrl addr range");
    doStop(0, "R5 no nv");

    for (int bp = 0; bp < 8; bp++) begin
      setBp(bp);
      foreach (addrs[k]) arrWrite(addrs[k], 1 - protExp(bp, addrs[k]), $sformatf("R11 bp%0d addr %0h", bp, addrs[k]));
    end

    doStart(); doSlave(8'hAE, 1, "R11 increment"); doAddr('h1FE, 1, "R11 increment");
    doData(8'h1, 0, "R11 1FE protected"); doData(8'h1, 0, "R11 1FF protected");
    doData(8'h1, 1, "R11 200 open"); doStop(1, "R7 nv"); waitIdle();

    statusWrite(8'h00, "R2 clear");
    chk("R2 cleared", int'(statusOut), 'h00);
    arrWrite('h7FF, 0, "R4 array after clear");

    @(negedge clk); rstN = 0; lostAllPower = 0;
    repeat (2) @(negedge clk); rstN = 1;
    @(negedge clk);
    chk("R1 status without power loss", int'(statusOut), 'h00);
    chk("R12 bp back to BP_INIT", int'(bpOut), 0);
    chk("R1 scoreboard drained", expQ.size(), 0);
    finishRun();
  end
endmodule